// File: doc/BRIEF.md
# Fully Associative LRU Tag Store with Multi-Size Hit Profiling

This block is a fully associative tag array that keeps its entries in exact least-recently-used order. Each lookup compares the presented block tag against every valid entry at once. On a hit, the entry is promoted to most-recently-used. On a miss, the least-recently-used entry is retagged with the new block and promoted.

Alongside the real outcome, each access is also judged against a family of smaller LRU caches. Their sizes begin at `BASE` entries and double up to half the full capacity. An entry would still sit in a smaller cache of size S exactly when its recency position is below S. From that rule the block derives a per-access inclusion mask and keeps hit and miss counters for every size in one pass. It also counts replacements of valid entries, tracks how many entries have ever been filled, and raises a warm flag once all of them are filled.

A requester presents a tag with a valid/ready handshake. The response arrives one cycle later and carries the hit indication, the inclusion mask and the selected way.

Top module: `fa_lru_tags`

## Requirements
- R1: While reset is low, and on the first response-free cycles after it, the response valid, replacement count, in-use count, warm flag and every hit and miss counter are zero. Way k holds recency position k, so way 0 is most recent and way N-1 is least recent.
- R2: A request accepted in cycle t produces `rsp_valid` in cycle t+1. At that point `rsp_hit` is 1 exactly when a valid entry holds the tag. On a hit, `rsp_way` is the index of the matching way.
- R3: On a hit, `rsp_mask` bit i (bit 0 = smallest size) is 1 exactly when the entry's recency position before the access (0 = most recent) is below BASE·2^i. On a miss, `rsp_mask` is zero.
- R4: A hit moves its entry to position 0. Every entry that was more recent moves back by one position, and all other entries keep their positions.
- R5: A miss selects the entry at position N-1. That entry is given the requested tag, marked valid, and moved to position 0, and its index is returned in `rsp_way`.
- R6: On a hit, for each tracked size i, `hit_cnt[i]` increments if mask bit i is set and `miss_cnt[i]` increments otherwise. The full-size counter `hit_cnt[NS]` always increments.
- R7: On a miss, `miss_cnt[i]` increments for every i from 0 to NS, which includes the full size.
- R8: `repl_cnt` increments when a miss selects an entry that was already valid.
- R9: `in_use` increments when a miss fills an invalid entry and never exceeds N. `warm` rises in the cycle in which `in_use` reaches N and then stays set.
- R10: `req_ready` is high whenever reset is released, so one request is accepted every cycle. A cycle with `req_valid` low produces no response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted |
| req_tag | input | TAG_W | Block-aligned tag to look up |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_mask | output | NS | Smaller sizes that also hit |
| rsp_way | output | IDX_W | Hit way or victim way |
| hit_cnt | output | (NS+1)×CNT_W | Hit counters per size, index NS = full size |
| miss_cnt | output | (NS+1)×CNT_W | Miss counters per size, index NS = full size |
| repl_cnt | output | CNT_W | Valid entries replaced |
| in_use | output | IDX_W+1 | Entries filled since reset |
| warm | output | 1 | All entries have been filled |

## Verification
Two things can happen in the same cycle. A hit on the entry sitting exactly at a size boundary updates both its own promotion and the mask seen for that size. Separately, the final filling miss sets `warm` in the same cycle that `in_use` reaches N. The bench sweeps a hit over every recency depth, back to back, so the boundary entries are hit in consecutive cycles. It then checks the mask bit against the position computed by its own list model. It also watches the sixteenth fill, checking that `warm` is still clear before that access and set after it, and that it stays set while later misses begin to count replacements.

// File: rtl/fa_lru_tags.sv
module fa_lru_tags #(
  parameter int N     = 16,
  parameter int BASE  = 2,
  parameter int TAG_W = 12,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(N),
  localparam int NS    = $clog2(N) - $clog2(BASE)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [TAG_W-1:0]              req_tag,
  output logic                          rsp_valid,
  output logic                          rsp_hit,
  output logic [NS-1:0]                 rsp_mask,
  output logic [IDX_W-1:0]              rsp_way,
  output logic [NS:0][CNT_W-1:0]        hit_cnt,
  output logic [NS:0][CNT_W-1:0]        miss_cnt,
  output logic [CNT_W-1:0]              repl_cnt,
  output logic [IDX_W:0]                in_use,
  output logic                          warm
);

  logic [TAG_W-1:0] tag_q  [N];
  logic [IDX_W-1:0] rank_q [N];
  logic [N-1:0]     vld_q;

  logic             hit;
  logic [IDX_W-1:0] hit_idx, tail_idx, sel;
  logic [IDX_W-1:0] sel_rank;
  logic [NS-1:0]    sel_mask;
  logic             fire;

  assign req_ready = rst_n;
  assign fire      = req_valid && req_ready;

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    tail_idx = '0;
    for (int k = 0; k < N; k++) begin
      if (vld_q[k] && tag_q[k] == req_tag) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(k);
      end
      if (rank_q[k] == IDX_W'(N - 1)) tail_idx = IDX_W'(k);
    end
  end

  assign sel      = hit ? hit_idx : tail_idx;
  assign sel_rank = rank_q[sel];

  always_comb
    for (int i = 0; i < NS; i++)
      sel_mask[i] = hit && (int'(sel_rank) < (BASE << i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        tag_q[k]  <= '0;
        rank_q[k] <= IDX_W'(k);
      end
      vld_q     <= '0;
      hit_cnt   <= '0;
      miss_cnt  <= '0;
      repl_cnt  <= '0;
      in_use    <= '0;
      warm      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_mask  <= '0;
      rsp_way   <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_hit  <= hit;
        rsp_mask <= sel_mask;
        rsp_way  <= sel;
        for (int k = 0; k < N; k++) begin
          if (IDX_W'(k) == sel)             rank_q[k] <= '0;
          else if (rank_q[k] < sel_rank)    rank_q[k] <= rank_q[k] + 1'b1;
        end
        for (int i = 0; i < NS; i++) begin
          if (sel_mask[i]) hit_cnt[i]  <= hit_cnt[i] + 1'b1;
          else             miss_cnt[i] <= miss_cnt[i] + 1'b1;
        end
        if (hit) hit_cnt[NS]  <= hit_cnt[NS] + 1'b1;
        else     miss_cnt[NS] <= miss_cnt[NS] + 1'b1;
        if (!hit) begin
          tag_q[sel] <= req_tag;
          vld_q[sel] <= 1'b1;
          if (vld_q[sel]) repl_cnt <= repl_cnt + 1'b1;
          else begin
            in_use <= in_use + 1'b1;
            if (in_use == (IDX_W+1)'(N - 1)) warm <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/fa_lru_tags_chk.sv
module fa_lru_tags_chk #(
  parameter int N     = 16,
  parameter int BASE  = 2,
  parameter int TAG_W = 12,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(N),
  localparam int NS    = $clog2(N) - $clog2(BASE)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [TAG_W-1:0]       req_tag,
  input logic                   rsp_valid,
  input logic                   rsp_hit,
  input logic [NS-1:0]          rsp_mask,
  input logic [IDX_W-1:0]       rsp_way,
  input logic [NS:0][CNT_W-1:0] hit_cnt,
  input logic [NS:0][CNT_W-1:0] miss_cnt,
  input logic [CNT_W-1:0]       repl_cnt,
  input logic [IDX_W:0]         in_use,
  input logic                   warm
);

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid && req_ready));

  assert_miss_mask_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_mask == '0);

  assert_mask_nested_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((NS'(rsp_mask << 1) & ~rsp_mask) == '0));

  assert_access_counted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> CNT_W'(hit_cnt[NS] + miss_cnt[NS]) ==
                  CNT_W'($past(hit_cnt[NS]) + $past(miss_cnt[NS]) + 1'b1));

  assert_repl_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (repl_cnt != $past(repl_cnt)) |-> int'($past(in_use)) == N);

  assert_warm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(warm) |-> warm);

  assert_warm_means_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> int'(in_use) == N);

  assert_in_use_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(in_use) <= N);

endmodule

bind fa_lru_tags fa_lru_tags_chk #(.N(N), .BASE(BASE), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/fa_lru_tags_test.sv
`timescale 1ns/1ps
module fa_lru_tags_test;
  localparam int N = 16, BASE = 2, TAG_W = 12, CNT_W = 16;
  localparam int IDX_W = $clog2(N);
  localparam int NS = $clog2(N) - $clog2(BASE);

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [TAG_W-1:0] req_tag = '0;
  logic req_ready, rsp_valid, rsp_hit, warm;
  logic [NS-1:0] rsp_mask;
  logic [IDX_W-1:0] rsp_way;
  logic [NS:0][CNT_W-1:0] hit_cnt, miss_cnt;
  logic [CNT_W-1:0] repl_cnt;
  logic [IDX_W:0] in_use;

  always #10 clk = ~clk;

  fa_lru_tags #(.N(N), .BASE(BASE), .TAG_W(TAG_W), .CNT_W(CNT_W)) uut (.*);

  int checks = 0, fails = 0;
  int ord [N];
  int mtag [N];
  bit mvld [N];
  int ehit [NS+1], emiss [NS+1];
  int erepl = 0, einuse = 0;
  bit ewarm = 0, done = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_counters(string req);
    for (int i = 0; i <= NS; i++) begin
      chk(req, $sformatf("hit_cnt[%0d]", i), int'(hit_cnt[i]), ehit[i]);
      chk(req, $sformatf("miss_cnt[%0d]", i), int'(miss_cnt[i]), emiss[i]);
    end
    chk("R8", "repl_cnt", int'(repl_cnt), erepl);
    chk("R9", "in_use", int'(in_use), einuse);
    chk("R9", "warm", int'(warm), int'(ewarm));
  endtask

  // one request, response checked at the next falling edge
  task automatic access(int tag);
    int p = N - 1, w, emask = 0;
    bit h = 0;
    for (int q = 0; q < N; q++)
      if (!h && mvld[ord[q]] && mtag[ord[q]] == tag) begin h = 1; p = q; end
    w = ord[p];
    if (h) for (int i = 0; i < NS; i++) if (p < (BASE << i)) emask |= (1 << i);
    req_valid = 1; req_tag = TAG_W'(tag);
    @(negedge clk);
    chk("R2", "rsp_valid", int'(rsp_valid), 1);
    chk("R2", "rsp_hit", int'(rsp_hit), int'(h));
    chk(h ? "R4" : "R5", "rsp_way", int'(rsp_way), w);
    chk("R3", "rsp_mask", int'(rsp_mask), emask);
    for (int q = p; q > 0; q--) ord[q] = ord[q-1];
    ord[0] = w;
    for (int i = 0; i < NS; i++) if (emask[i]) ehit[i]++; else emiss[i]++;
    if (h) ehit[NS]++;
    else begin
      emiss[NS]++;
      if (mvld[w]) erepl++; else einuse++;
      if (einuse == N) ewarm = 1;
      mvld[w] = 1; mtag[w] = tag;
    end
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin ord[k] = k; mvld[k] = 0; mtag[k] = 0; end
    for (int i = 0; i <= NS; i++) begin ehit[i] = 0; emiss[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R10", "req_ready in reset", int'(req_ready), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R10", "req_ready", int'(req_ready), 1);
    check_counters("R1");
    // fill: ways come out N-1 down to 0
    for (int k = 0; k < N; k++) begin
      access(256 + k);
      chk("R9", "warm during fill", int'(warm), int'(k == N - 1));
    end
    check_counters("R7");
    // R3/R4: hit at every recency depth, back to back
    for (int rep = 0; rep < 2; rep++)
      for (int d = 0; d < N; d++) access(mtag[ord[d]]);
    for (int d = N - 1; d >= 0; d--) access(mtag[ord[d]]);
    check_counters("R6");
    // R8: replacements of valid entries
    for (int k = 0; k < 20; k++) access(512 + k);
    check_counters("R8");
    // mixed pattern over a working set larger than capacity
    for (int k = 0; k < 300; k++) access(256 + (k * 7) % 24 + ((k / 50) % 2) * 3);
    // R10: idle cycles produce nothing and change nothing
    req_valid = 0; req_tag = TAG_W'(257);
    repeat (3) begin
      @(negedge clk);
      chk("R10", "rsp_valid idle", int'(rsp_valid), 0);
    end
    check_counters("R10");
    access(mtag[ord[N-1]]);
    access(mtag[ord[BASE]]);
    req_valid = 0;
    @(negedge clk);
    check_counters("R6");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule